// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Clock

A 16-bit timer/counter for a microcontroller subsystem. The timer advances on every clock (timer mode) or on falling edges of a synchronized count pin (counter mode). At the top of its range it wraps either to a programmable reload value or to zero. A synchronized trigger pin, when enabled, can either reload the count or capture it into a capture register. Software reaches all state through a byte-wide register port with eight addresses.

The timer can also supply the baud clock for a serial port. Separate selects for the receive and transmit paths choose between this timer's wrap pulse and an externally supplied timer-1 overflow pulse. While either select is set, the timer always reloads on wrap, never raises its overflow flag, and ignores the trigger pin.

An optional up/down mode uses the trigger pin level as the count direction. In this mode a wrap in either direction toggles the external flag, and that flag is kept out of the interrupt request.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and both baud tick outputs are low.
- R2: With run (control bit 1) at 1 and count select (bit 5) at 0, the count advances by one on every clock. With run at 0 the count holds its value.
- R3: With count select at 1, the count advances once for each falling edge of `cnt_pin_i`. The pin passes through a two-flop synchronizer, and one edge gives exactly one advance.
- R4: Counting up from 0xFFFF with capture select (bit 7) at 0 loads the reload register and sets the overflow flag (bit 0). The flag stays set until a software write to the control register clears it.
- R5: With capture select at 1, the count wraps from 0xFFFF to 0x0000 and sets the overflow flag. With external enable (bit 6) at 1, a falling edge on `trig_pin_i` copies the count into the capture register and sets the external flag (bit 2).
- R6: With capture select at 0 and external enable at 1, a falling trigger edge loads the reload value into the count and sets the external flag. With external enable at 0, trigger edges have no effect.
- R7: While receive select (bit 4) or transmit select (bit 3) is 1, a wrap always reloads, the overflow flag is not set, and trigger edges are ignored.
- R8: `rx_baud_tick_o` is a one-clock pulse, one cycle after this timer's wrap when receive select is 1, or one cycle after `t1_ovf_i` when it is 0. `tx_baud_tick_o` does the same under transmit select.
- R9: `irq_o` is the OR of the overflow flag and the external flag. The external flag is left out while up/down mode is active.
- R10: With the mode register bit 0 at 1 and no baud select, the count goes up while `trig_pin_i` is high and down while it is low. Going down from 0x0000 loads the reload value. Each wrap sets the overflow flag and toggles the external flag.
- R11: When a hardware set or toggle of a flag falls in the same cycle as a software write to the control register, the hardware action wins over the written value.
- R12: The register addresses are: 0 control, 1 mode, 2 and 3 reload low and high, 4 and 5 count low and high, 6 and 7 capture low and high (read-only). Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for the addressed register |
| cnt_pin_i | input | 1 | External count pin, falling-edge active |
| trig_pin_i | input | 1 | External trigger pin; sets direction in up/down mode |
| t1_ovf_i | input | 1 | Timer-1 overflow pulse, the alternate baud source |
| irq_o | output | 1 | Interrupt request |
| rx_baud_tick_o | output | 1 | Receive baud tick |
| tx_baud_tick_o | output | 1 | Transmit baud tick |

## Verification
The hardest case to reach is a hardware flag event that lands in exactly the same clock as a software write to the control register. The trigger path goes through the synchronizer and the edge detector, so the event is registered two clocks after the pin falls. The bench drops the pin on a falling clock edge and waits two falling edges before issuing the write. It also sets up an up/down wrap so that it lands on the edge where a stop write is latched. In both cases the written value would clear the flag, so a flag read back as set shows that the hardware action took priority.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_MODE   = 3'd1,
    A_RLD_LO = 3'd2,
    A_RLD_HI = 3'd3,
    A_CNT_LO = 3'd4,
    A_CNT_HI = 3'd5,
    A_CAP_LO = 3'd6,
    A_CAP_HI = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic cap_sel;  // 1: trigger captures, 0: reload
    logic ext_en;   // trigger pin enable
    logic cnt_sel;  // 1: count pin edges, 0: clock
    logic rx_sel;   // receive baud from this timer
    logic tx_sel;   // transmit baud from this timer
    logic exf;      // external flag
    logic run;      // run control
    logic ovf;      // overflow flag
  } ctrl_t;
endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~level_o;

  // one pin edge yields a single-cycle event
  assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/crt_counter.sv
module crt_counter
  import crt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ud_i,
  input  logic              up_i,
  input  logic              reload_wrap_i,
  input  logic              ext_reload_i,
  input  logic              ext_capture_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  reload_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  capture_o,
  output logic              wrap_evt_o
);
  logic [CNT_W-1:0] count_q, capture_q, count_d;
  logic             going_up, sw_wr;

  function automatic logic at_limit(input logic [CNT_W-1:0] c, input logic up);
    return up ? (c == {CNT_W{1'b1}}) : (c == '0);
  endfunction

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                              input logic up, input logic wrap,
                                              input logic to_reload,
                                              input logic [CNT_W-1:0] rld);
    if (wrap) return to_reload ? rld : '0;
    return up ? c + 1'b1 : c - 1'b1;
  endfunction

  assign going_up   = ud_i ? up_i : 1'b1;
  assign sw_wr      = wr_lo_i | wr_hi_i;
  assign wrap_evt_o = tick_i & ~sw_wr & ~ext_reload_i & at_limit(count_q, going_up);

  always_comb begin
    count_d = count_q;
    if (sw_wr) begin
      if (wr_lo_i) count_d[DATA_W-1:0]     = wr_data_i;
      if (wr_hi_i) count_d[CNT_W-1:DATA_W] = wr_data_i;
    end else if (ext_reload_i) begin
      count_d = reload_i;
    end else if (tick_i) begin
      count_d = advance(count_q, going_up, wrap_evt_o, reload_wrap_i, reload_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      capture_q <= '0;
    end else begin
      count_q <= count_d;
      if (ext_capture_i) capture_q <= count_q;
    end
  end

  assign count_o   = count_q;
  assign capture_o = capture_q;

  assert_capture_takes_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_capture_i |=> capture_o == $past(count_o));
  assert_ext_reload_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_reload_i && !sw_wr) |=> count_o == $past(reload_i));
  assert_underflow_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt_o && ud_i && !up_i) |=> count_o == $past(reload_i));
  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !sw_wr && !ext_reload_i) |=> $stable(count_o));
endmodule

// File: rtl/crt_ctrl_regs.sv
module crt_ctrl_regs
  import crt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl_i,
  input  logic              wr_mode_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wrap_evt_i,
  input  logic              ext_evt_i,
  output ctrl_t             ctrl_o,
  output logic              ud_en_o,
  output logic              baud_o,
  output logic              ud_active_o,
  output logic              irq_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  ud_q;
  logic  ovf_set, exf_tgl;

  assign baud_o      = ctrl_q.rx_sel | ctrl_q.tx_sel;
  assign ud_active_o = ud_q & ~baud_o;
  assign ovf_set     = wrap_evt_i & ~baud_o;
  assign exf_tgl     = wrap_evt_i & ud_active_o;

  always_comb begin
    ctrl_d = wr_ctrl_i ? ctrl_t'(wr_data_i) : ctrl_q;
    if (ovf_set)        ctrl_d.ovf = 1'b1;
    if (ext_evt_i)      ctrl_d.exf = 1'b1;
    else if (exf_tgl)   ctrl_d.exf = ~ctrl_q.exf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ud_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_mode_i) ud_q <= wr_data_i[0];
    end
  end

  assign ctrl_o  = ctrl_q;
  assign ud_en_o = ud_q;
  assign irq_o   = ctrl_q.ovf | (ctrl_q.exf & ~ud_q);

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o.ovf && !wr_ctrl_i) |=> ctrl_o.ovf);
  assert_no_ovf_in_baud_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_o && !ctrl_o.ovf && !wr_ctrl_i) |=> !ctrl_o.ovf);
  assert_hw_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt_i |=> ctrl_o.exf);
  assert_wrap_sets_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt_i && !baud_o) |=> ctrl_o.ovf);
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cnt_pin_i,
  input  logic              trig_pin_i,
  input  logic              t1_ovf_i,
  output logic              irq_o,
  output logic              rx_baud_tick_o,
  output logic              tx_baud_tick_o
);
  localparam int N_PINS = 2;
  localparam int PIN_CNT = 0;
  localparam int PIN_TRG = 1;

  logic [N_PINS-1:0] pin_raw, pin_lvl, pin_fall;
  ctrl_t             ctrl;
  logic              ud_en, baud, ud_active;
  logic              tick, wrap_evt, ext_evt, ext_reload, ext_capture;
  logic [CNT_W-1:0]  reload_q, count, capture;
  logic              rx_tick_q, tx_tick_q;
  logic              wr_ctrl, wr_mode, wr_rlo, wr_rhi, wr_clo, wr_chi;

  assign pin_raw[PIN_CNT] = cnt_pin_i;
  assign pin_raw[PIN_TRG] = trig_pin_i;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    crt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_raw[g]),
      .level_o(pin_lvl[g]),
      .fall_o (pin_fall[g])
    );
  end

  // register write decode
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_mode = wr_en_i && (addr_i == A_MODE);
  assign wr_rlo  = wr_en_i && (addr_i == A_RLD_LO);
  assign wr_rhi  = wr_en_i && (addr_i == A_RLD_HI);
  assign wr_clo  = wr_en_i && (addr_i == A_CNT_LO);
  assign wr_chi  = wr_en_i && (addr_i == A_CNT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else begin
      if (wr_rlo) reload_q[DATA_W-1:0]     <= wr_data_i;
      if (wr_rhi) reload_q[CNT_W-1:DATA_W] <= wr_data_i;
    end
  end

  // event qualification
  assign tick        = ctrl.run & (ctrl.cnt_sel ? pin_fall[PIN_CNT] : 1'b1);
  assign ext_evt     = ctrl.ext_en & pin_fall[PIN_TRG] & ~baud & ~ud_active;
  assign ext_reload  = ext_evt & ~ctrl.cap_sel;
  assign ext_capture = ext_evt & ctrl.cap_sel;

  crt_ctrl_regs u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl_i  (wr_ctrl),
    .wr_mode_i  (wr_mode),
    .wr_data_i  (wr_data_i),
    .wrap_evt_i (wrap_evt),
    .ext_evt_i  (ext_evt),
    .ctrl_o     (ctrl),
    .ud_en_o    (ud_en),
    .baud_o     (baud),
    .ud_active_o(ud_active),
    .irq_o      (irq_o)
  );

  crt_counter u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .ud_i         (ud_active),
    .up_i         (pin_lvl[PIN_TRG]),
    .reload_wrap_i(baud | ~ctrl.cap_sel | ud_active),
    .ext_reload_i (ext_reload),
    .ext_capture_i(ext_capture),
    .wr_lo_i      (wr_clo),
    .wr_hi_i      (wr_chi),
    .wr_data_i    (wr_data_i),
    .reload_i     (reload_q),
    .count_o      (count),
    .capture_o    (capture),
    .wrap_evt_o   (wrap_evt)
  );

  // baud tick selection, registered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_tick_q <= 1'b0;
      tx_tick_q <= 1'b0;
    end else begin
      rx_tick_q <= ctrl.rx_sel ? wrap_evt : t1_ovf_i;
      tx_tick_q <= ctrl.tx_sel ? wrap_evt : t1_ovf_i;
    end
  end
  assign rx_baud_tick_o = rx_tick_q;
  assign tx_baud_tick_o = tx_tick_q;

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_CTRL:   rd_data_o = ctrl;
      A_MODE:   rd_data_o = {{(DATA_W-1){1'b0}}, ud_en};
      A_RLD_LO: rd_data_o = reload_q[DATA_W-1:0];
      A_RLD_HI: rd_data_o = reload_q[CNT_W-1:DATA_W];
      A_CNT_LO: rd_data_o = count[DATA_W-1:0];
      A_CNT_HI: rd_data_o = count[CNT_W-1:DATA_W];
      A_CAP_LO: rd_data_o = capture[DATA_W-1:0];
      A_CAP_HI: rd_data_o = capture[CNT_W-1:DATA_W];
      default:  rd_data_o = '0;
    endcase
  end

  assert_rx_follows_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.rx_sel && wrap_evt) |=> rx_baud_tick_o);
  assert_tx_follows_t1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.tx_sel && t1_ovf_i) |=> tx_baud_tick_o);
  assert_baud_blocks_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !wr_ctrl && !wr_clo && !wr_chi && !ctrl.run) |=> $stable(count));
endmodule

// File: tb/cap_reload_timer_bench.sv
module cap_reload_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       cnt_pin_i = 1'b1;
  logic       trig_pin_i = 1'b1;
  logic       t1_ovf_i = 1'b0;
  logic       irq_o, rx_baud_tick_o, tx_baud_tick_o;

  int checks = 0;
  int errors = 0;
  int rx_seen = 0;
  int tx_seen = 0;
  bit finished = 1'b0;

  cap_reload_timer u_cap_reload_timer (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .cnt_pin_i(cnt_pin_i),
    .trig_pin_i(trig_pin_i), .t1_ovf_i(t1_ovf_i), .irq_o(irq_o),
    .rx_baud_tick_o(rx_baud_tick_o), .tx_baud_tick_o(tx_baud_tick_o)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rx_baud_tick_o) rx_seen++;
    if (tx_baud_tick_o) tx_seen++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling clock edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr_i = a; #1; v = int'(rd_data_o);
  endtask

  task automatic rd16(input logic [2:0] a_lo, output int v);
    int lo, hi;
    rd(a_lo, lo); rd(a_lo + 3'd1, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic wr16(input logic [2:0] a_lo, input int v);
    wr(a_lo, v[7:0]); wr(a_lo + 3'd1, v[15:8]);
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 register after reset", v, 0);
    end
    chk("R1 irq after reset", int'(irq_o), 0);
    chk("R1 rx tick after reset", int'(rx_baud_tick_o), 0);
    chk("R1 tx tick after reset", int'(tx_baud_tick_o), 0);
  endtask

  task automatic t_reload_overflow;
    int v;
    wr16(3'd2, 'h1234);
    rd16(3'd2, v); chk("R12 reload readback", v, 'h1234);
    wr16(3'd4, 'hFFFD);
    wr(3'd0, 8'h02);
    idle(4);
    wr(3'd0, 8'h01);                 // stop, keep flag: 5 advances
    rd16(3'd4, v); chk("R4 reload after wrap", v, 'h1236);
    rd(3'd0, v);   chk("R4 overflow flag set", v, 'h01);
    chk("R9 irq from overflow", int'(irq_o), 1);
    idle(3);
    rd16(3'd4, v); chk("R2 count holds with run 0", v, 'h1236);
    wr(3'd0, 8'h00);
    rd(3'd0, v);   chk("R4 software clears flag", v, 0);
    chk("R9 irq cleared", int'(irq_o), 0);
  endtask

  task automatic t_capture_wrap;
    int v;
    wr16(3'd4, 'hFFFE);
    wr(3'd0, 8'h82);
    idle(2);
    wr(3'd0, 8'h81);                 // 3 advances
    rd16(3'd4, v); chk("R5 wrap to zero", v, 'h0001);
    rd(3'd0, v);   chk("R5 overflow in capture mode", v, 'h81);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_capture_trigger;
    int v;
    wr16(3'd4, 'h4321);
    wr(3'd0, 8'hC0);
    trig_pin_i = 1'b0; idle(4);
    rd16(3'd6, v); chk("R5 capture register", v, 'h4321);
    rd(3'd0, v);   chk("R5 external flag set", v, 'hC4);
    chk("R9 irq from external flag", int'(irq_o), 1);
    trig_pin_i = 1'b1; idle(3);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_reload_trigger;
    int v;
    wr16(3'd2, 'hABCD);
    wr16(3'd4, 'h5555);
    wr(3'd0, 8'h40);
    trig_pin_i = 1'b0; idle(4);
    rd16(3'd4, v); chk("R6 trigger reload", v, 'hABCD);
    rd(3'd0, v);   chk("R6 external flag", v, 'h44);
    trig_pin_i = 1'b1; idle(3);
    wr(3'd0, 8'h00);
    wr16(3'd4, 'h1111);
    trig_pin_i = 1'b0; idle(4);
    rd16(3'd4, v); chk("R6 disabled trigger keeps count", v, 'h1111);
    rd(3'd0, v);   chk("R6 disabled trigger no flag", v, 0);
    rd16(3'd6, v); chk("R6 disabled trigger no capture", v, 'h4321);
    trig_pin_i = 1'b1; idle(3);
  endtask

  task automatic t_hw_wins;
    int v;
    wr(3'd0, 8'h40);
    trig_pin_i = 1'b0; idle(2);
    wr(3'd0, 8'h40);                 // clear attempt in event cycle
    rd(3'd0, v); chk("R11 hardware set beats write", v, 'h44);
    trig_pin_i = 1'b1; idle(3);
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R11 later write clears", v, 0);
  endtask

  task automatic t_baud;
    int v, r0, t0;
    wr16(3'd4, 'h2222);
    wr(3'd0, 8'hD0);
    trig_pin_i = 1'b0; idle(4);
    rd16(3'd4, v); chk("R7 trigger ignored in baud mode", v, 'h2222);
    rd(3'd0, v);   chk("R7 no external flag in baud mode", v, 'hD0);
    trig_pin_i = 1'b1; idle(3);
    wr16(3'd2, 'hFFFE);
    wr16(3'd4, 'hFFFE);
    r0 = rx_seen;
    wr(3'd0, 8'hD2);
    idle(20);
    wr(3'd0, 8'hD0);                 // 21 advances, 10 wraps
    idle(2);
    chk("R8 rx ticks from timer wraps", rx_seen - r0, 10);
    rd(3'd0, v);   chk("R7 no overflow flag in baud mode", v, 'hD0);
    rd16(3'd4, v); chk("R7 forced reload in baud mode", v, 'hFFFF);
    r0 = rx_seen; t0 = tx_seen;
    for (int i = 0; i < 3; i++) begin
      t1_ovf_i = 1'b1; idle(1); t1_ovf_i = 1'b0; idle(2);
    end
    chk("R8 tx ticks follow timer-1", tx_seen - t0, 3);
    chk("R8 rx ignores timer-1 when selected", rx_seen - r0, 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_counter_mode;
    int v;
    wr16(3'd4, 'h0010);
    wr(3'd0, 8'h22);
    for (int i = 0; i < 3; i++) begin
      cnt_pin_i = 1'b0; idle(3); cnt_pin_i = 1'b1; idle(3);
    end
    wr(3'd0, 8'h20);
    rd16(3'd4, v); chk("R3 one advance per pin edge", v, 'h0013);
    cnt_pin_i = 1'b0; idle(3); cnt_pin_i = 1'b1; idle(3);
    rd16(3'd4, v); chk("R2 stopped counter ignores edges", v, 'h0013);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_updown;
    int v;
    wr16(3'd2, 'h0100);
    wr16(3'd4, 'h0002);
    wr(3'd1, 8'h01);
    trig_pin_i = 1'b0; idle(4);
    wr(3'd0, 8'h02);
    idle(4);
    rd(3'd0, v); chk("R10 underflow sets ovf and toggles exf", v, 'h07);
    wr(3'd0, 8'h04);                 // stop: 5 decrements
    rd16(3'd4, v); chk("R10 down count with reload", v, 'h00FE);
    chk("R9 external flag masked in up/down", int'(irq_o), 0);
    wr(3'd1, 8'h00);
    chk("R9 external flag unmasked", int'(irq_o), 1);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h00);
    trig_pin_i = 1'b1; idle(4);
    wr16(3'd4, 'hFFFE);
    wr(3'd0, 8'h02);
    idle(1);
    wr(3'd0, 8'h00);                 // wrap falls on this write
    rd16(3'd4, v); chk("R10 up count wraps to reload", v, 'h0100);
    rd(3'd0, v);   chk("R11 toggle and set beat write", v, 'h05);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reload_overflow();
    t_capture_wrap();
    t_capture_trigger();
    t_reload_trigger();
    t_hw_wins();
    t_baud();
    t_counter_mode();
    t_updown();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule